// File: doc/BRIEF.md
# Clock Divider Power-Down Restore Sequencer

This block powers one high-speed PLL output divider down and back up without losing its programmed divide value. Setting a divider's power-down bit resets its divide value to the reset default. The divider's internal state machine also takes a new value only when the value actually changes. A plain write of the intended value after power-down may therefore be lost.

A host raises `start_i` with a channel number and the intended divide value. The sequencer then works through a fixed series of accesses on a simple register master port, waiting for an acknowledge on each one:

1. It gates the functional and interface clock enables that depend on the channel.
2. It sets and then clears the channel's power-down bit.
3. It reads the divide register.
4. It writes a value that differs from the intended one, then writes the intended value.
5. It restores only those clock enables that were set before it began.

Every write is a read-modify-write. Only the channel's own bit or field changes; all other bits keep their value.

An access with no acknowledge ends after a bounded wait. The sequencer then skips ahead to the restore accesses and reports an error together with `done_o`.

Register map at the default parameters:

| Register | Address | Channel bit or field |
|---|---|---|
| Functional clock enables | 0x00 | bit = channel |
| Interface clock enables | 0x01 | bit = channel |
| Power-down register A | 0x02 | channel 0 at bit 12 |
| Power-down register B | 0x03 | channel k (1..5) at bit 25+k |
| Divide register | 0x10 + channel | divide value in bits [4:0] |

Top module: `hsdiv_reload_seq`

## Requirements
- R1: After an accepted start, the port performs exactly 14 accesses, in this order:
  1. read of functional enables (0x00)
  2. write of functional enables (0x00)
  3. read of interface enables (0x01)
  4. write of interface enables (0x01)
  5. read of the power-down register
  6. write of the power-down register
  7. write of the power-down register
  8. read of the divide register
  9. write of the divide register
  10. write of the divide register
  11. read of functional enables (0x00)
  12. write of functional enables (0x00)
  13. read of interface enables (0x01)
  14. write of interface enables (0x01)
- R2: The gating writes clear only bit `chan` of the value read from each enable register and keep every other bit.
- R3: The first power-down write sets the channel's bit and the second clears it. Channel 0 uses bit 12 of register 0x02; channel k≥1 uses bit 25+k of register 0x03. All other bits equal the value read just before.
- R4: The scratch write carries target XOR 1 in bits [4:0], or 2 if that result is zero, and keeps the upper bits read from the divide register.
- R5: The following write carries the target in bits [4:0], with the upper bits kept, so the divide field ends at the target.
- R6: Each restore write ORs the channel bit into the freshly read enable value only if that bit was set when first read. A bit that was clear stays clear.
- R7: `busy_o`, `done_o`, `err_o` and `bus_req_o` are low out of reset. `done_o` pulses for one cycle after the last restore write, and `busy_o` is low in the cycle after.
- R8: A start while busy, or with `chan_i` ≥ 6, is ignored.
- R9: Each access holds its request, address and direction until acknowledged. An acknowledge that arrives in the last allowed wait cycle (cycle TO_CYC) counts as success.
- R10: If an access sees no acknowledge within TO_CYC wait cycles, the sequencer skips to the restore accesses, and `err_o` is high together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| start_i | input | 1 | request a reload sequence |
| chan_i | input | 3 | divider channel |
| target_i | input | 5 | intended divide value |
| busy_o | output | 1 | sequence in progress |
| done_o | output | 1 | one-cycle completion pulse |
| err_o | output | 1 | an access timed out (valid with done_o) |
| bus_req_o | output | 1 | access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 8 | register address |
| bus_wdata_o | output | 32 | write data |
| bus_rdata_i | input | 32 | read data, valid with ack |
| bus_ack_i | input | 1 | access complete |

## Verification
Two events can fall in the same cycle: the acknowledge of an access, and the expiry of that access's wait limit. The bench's register model holds back each acknowledge by exactly TO_CYC cycles, so every acknowledge lands in the very cycle the timeout would fire. The run is judged by a full, correct access trace that ends with `err_o` low. A second run never acknowledges the divide register, and must end with the restore accesses and with `err_o` high alongside `done_o`.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FRD, ST_FWR, ST_IRD, ST_IWR, ST_PRD, ST_PSET, ST_PCLR,
    ST_DRD, ST_DSCR, ST_DTGT, ST_RFRD, ST_RFWR, ST_RIRD, ST_RIWR, ST_DONE
  } step_e;

  function automatic logic step_is_rd(step_e s);
    return (s == ST_FRD) || (s == ST_IRD) || (s == ST_PRD) || (s == ST_DRD) ||
           (s == ST_RFRD) || (s == ST_RIRD);
  endfunction
endpackage

// File: rtl/hsdiv_bus_wait.sv
module hsdiv_bus_wait #(
  parameter int TO_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ack_i,
  output logic to_o
);
  localparam int CW = $clog2(TO_CYC + 1);
  logic [CW-1:0] cnt_q;

  // ack in the limit cycle wins over timeout
  assign to_o = req_i && !ack_i && (cnt_q == CW'(TO_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!req_i || ack_i || to_o)  cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hsdiv_step_fsm.sv
module hsdiv_step_fsm
  import hsdiv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  chan_ok_i,
  input  logic  ack_i,
  input  logic  to_i,
  output step_e step_o,
  output logic  load_o,
  output logic  busy_o,
  output logic  done_o,
  output logic  err_o
);
  step_e step_q, step_d;
  logic  err_q;

  assign load_o = (step_q == ST_IDLE) && start_i && chan_ok_i;

  always_comb begin
    step_d = step_q;
    case (step_q)
      ST_IDLE: if (load_o) step_d = ST_FRD;
      ST_DONE: step_d = ST_IDLE;
      default: begin
        if (ack_i)     step_d = step_e'(step_q + 4'd1);
        else if (to_i) step_d = (step_q < ST_RFRD) ? ST_RFRD :
                                (step_q < ST_RIRD) ? ST_RIRD : ST_DONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= ST_IDLE;
      err_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      if (load_o)    err_q <= 1'b0;
      else if (to_i) err_q <= 1'b1;
    end
  end

  assign step_o = step_q;
  assign busy_o = (step_q != ST_IDLE);
  assign done_o = (step_q == ST_DONE);
  assign err_o  = done_o && err_q;
endmodule

// File: rtl/hsdiv_access_gen.sv
module hsdiv_access_gen
  import hsdiv_pkg::*;
#(
  parameter int          N_CH      = 6,
  parameter int          CH_W      = 3,
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          DIV_W     = 5,
  parameter logic [7:0]  FCLK_ADDR = 8'h00,
  parameter logic [7:0]  ICLK_ADDR = 8'h01,
  parameter logic [7:0]  PD_A_ADDR = 8'h02,
  parameter logic [7:0]  PD_B_ADDR = 8'h03,
  parameter logic [7:0]  DIV_BASE  = 8'h10,
  parameter int          PD_A_BIT  = 12,
  parameter int          PD_B_LO   = 26
) (
  input  step_e             step_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DIV_W-1:0]  tgt_i,
  input  logic [DW-1:0]     rd_i,
  input  logic              f_save_i,
  input  logic              i_save_i,
  output logic              req_o,
  output logic              we_o,
  output logic [AW-1:0]     addr_o,
  output logic [DW-1:0]     wdata_o,
  output logic [DW-1:0]     ck_mask_o
);
  localparam int NT = 2 ** CH_W;

  logic [DW-1:0] pd_tab  [NT];
  logic [DW-1:0] ck_tab  [NT];
  logic [AW-1:0] pda_tab [NT];
  logic [AW-1:0] dva_tab [NT];

  for (genvar c = 0; c < NT; c++) begin : g_ch
    if (c < N_CH) begin : g_on
      localparam int PB = (c == 0) ? PD_A_BIT : PD_B_LO + c - 1;
      assign pd_tab[c]  = DW'(1) << PB;
      assign ck_tab[c]  = DW'(1) << c;
      assign pda_tab[c] = (c == 0) ? AW'(PD_A_ADDR) : AW'(PD_B_ADDR);
      assign dva_tab[c] = AW'(DIV_BASE) + AW'(c);
    end else begin : g_off
      assign pd_tab[c]  = '0;
      assign ck_tab[c]  = '0;
      assign pda_tab[c] = '0;
      assign dva_tab[c] = '0;
    end
  end

  logic [DW-1:0]    pd_m, ck_m;
  logic [DIV_W-1:0] scr;

  assign pd_m      = pd_tab[chan_i];
  assign ck_m      = ck_tab[chan_i];
  assign ck_mask_o = ck_m;

  always_comb begin
    scr = tgt_i ^ DIV_W'(1);
    if (scr == '0) scr = DIV_W'(2);
  end

  assign req_o = (step_i != ST_IDLE) && (step_i != ST_DONE);
  assign we_o  = req_o && !step_is_rd(step_i);

  always_comb begin
    addr_o  = '0;
    wdata_o = '0;
    case (step_i)
      ST_FRD, ST_RFRD: addr_o = AW'(FCLK_ADDR);
      ST_IRD, ST_RIRD: addr_o = AW'(ICLK_ADDR);
      ST_FWR:  begin addr_o = AW'(FCLK_ADDR); wdata_o = rd_i & ~ck_m; end
      ST_IWR:  begin addr_o = AW'(ICLK_ADDR); wdata_o = rd_i & ~ck_m; end
      ST_PRD:  addr_o = pda_tab[chan_i];
      ST_PSET: begin addr_o = pda_tab[chan_i]; wdata_o = rd_i | pd_m; end
      ST_PCLR: begin addr_o = pda_tab[chan_i]; wdata_o = rd_i & ~pd_m; end
      ST_DRD:  addr_o = dva_tab[chan_i];
      ST_DSCR: begin addr_o = dva_tab[chan_i]; wdata_o = {rd_i[DW-1:DIV_W], scr}; end
      ST_DTGT: begin addr_o = dva_tab[chan_i]; wdata_o = {rd_i[DW-1:DIV_W], tgt_i}; end
      ST_RFWR: begin addr_o = AW'(FCLK_ADDR); wdata_o = rd_i | (f_save_i ? ck_m : '0); end
      ST_RIWR: begin addr_o = AW'(ICLK_ADDR); wdata_o = rd_i | (i_save_i ? ck_m : '0); end
      default: ;
    endcase
  end
endmodule

// File: rtl/hsdiv_reload_seq.sv
module hsdiv_reload_seq
  import hsdiv_pkg::*;
#(
  parameter int          N_CH      = 6,
  parameter int          AW        = 8,
  parameter int          DW        = 32,
  parameter int          DIV_W     = 5,
  parameter int          TO_CYC    = 16,
  parameter logic [7:0]  FCLK_ADDR = 8'h00,
  parameter logic [7:0]  ICLK_ADDR = 8'h01,
  parameter logic [7:0]  PD_A_ADDR = 8'h02,
  parameter logic [7:0]  PD_B_ADDR = 8'h03,
  parameter logic [7:0]  DIV_BASE  = 8'h10,
  parameter int          PD_A_BIT  = 12,
  parameter int          PD_B_LO   = 26,
  localparam int         CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CH_W-1:0]  chan_i,
  input  logic [DIV_W-1:0] target_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             bus_req_o,
  output logic             bus_we_o,
  output logic [AW-1:0]    bus_addr_o,
  output logic [DW-1:0]    bus_wdata_o,
  input  logic [DW-1:0]    bus_rdata_i,
  input  logic             bus_ack_i
);
  step_e            step;
  logic             load, to_hit, chan_ok;
  logic [CH_W-1:0]  chan_q;
  logic [DIV_W-1:0] tgt_q;
  logic [DW-1:0]    rd_q, ck_mask;
  logic             f_save_q, i_save_q;

  assign chan_ok = (32'(chan_i) < N_CH);

  hsdiv_step_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .chan_ok_i(chan_ok), .ack_i(bus_ack_i), .to_i(to_hit),
    .step_o(step), .load_o(load), .busy_o, .done_o, .err_o
  );

  hsdiv_bus_wait #(.TO_CYC(TO_CYC)) u_wait (
    .clk_i, .rst_ni, .req_i(bus_req_o), .ack_i(bus_ack_i), .to_o(to_hit)
  );

  hsdiv_access_gen #(
    .N_CH(N_CH), .CH_W(CH_W), .AW(AW), .DW(DW), .DIV_W(DIV_W),
    .FCLK_ADDR(FCLK_ADDR), .ICLK_ADDR(ICLK_ADDR), .PD_A_ADDR(PD_A_ADDR),
    .PD_B_ADDR(PD_B_ADDR), .DIV_BASE(DIV_BASE), .PD_A_BIT(PD_A_BIT), .PD_B_LO(PD_B_LO)
  ) u_gen (
    .step_i(step), .chan_i(chan_q), .tgt_i(tgt_q), .rd_i(rd_q),
    .f_save_i(f_save_q), .i_save_i(i_save_q),
    .req_o(bus_req_o), .we_o(bus_we_o), .addr_o(bus_addr_o), .wdata_o(bus_wdata_o),
    .ck_mask_o(ck_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q   <= '0;
      tgt_q    <= '0;
      rd_q     <= '0;
      f_save_q <= 1'b0;
      i_save_q <= 1'b0;
    end else if (load) begin
      chan_q   <= chan_i;
      tgt_q    <= target_i;
      f_save_q <= 1'b0;
      i_save_q <= 1'b0;
    end else if (bus_ack_i && bus_req_o && !bus_we_o) begin
      rd_q <= bus_rdata_i;
      if (step == ST_FRD) f_save_q <= |(bus_rdata_i & ck_mask);
      if (step == ST_IRD) i_save_q <= |(bus_rdata_i & ck_mask);
    end
  end
endmodule

// File: rtl/hsdiv_reload_seq_chk.sv
module hsdiv_reload_seq_chk #(
  parameter int AW = 8,
  parameter int CH_W = 3,
  parameter int DIV_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             err_o,
  input logic             bus_req_o,
  input logic             bus_we_o,
  input logic [AW-1:0]    bus_addr_o,
  input logic             bus_ack_i,
  input logic             to_hit,
  input logic [CH_W-1:0]  chan_q,
  input logic [DIV_W-1:0] tgt_q
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R7
  AST_REQ_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> busy_o); // R1
  AST_NO_REQ_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_req_o); // R1
  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i && !to_hit) |=>
      (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o))); // R9
  AST_ERR_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R10
  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(chan_q) && $stable(tgt_q))); // R8
endmodule

bind hsdiv_reload_seq hsdiv_reload_seq_chk #(.AW(AW), .CH_W(CH_W), .DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
  .bus_ack_i(bus_ack_i), .to_hit(to_hit), .chan_q(chan_q), .tgt_q(tgt_q)
);

// File: tb/hsdiv_reload_seq_tb_top.sv
module hsdiv_reload_seq_tb_top;
  localparam int TO_CYC = 16;
  localparam int FA = 8'h00, IA = 8'h01, PA = 8'h02, PB = 8'h03, DB = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] chan = '0;
  logic [4:0] tgt = '0;
  logic busy, done, err, req, we, ack = 1'b0;
  logic [7:0] addr;
  logic [31:0] wdata, rdata = '0;

  always #5 clk = ~clk;

  hsdiv_reload_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .target_i(tgt),
    .busy_o(busy), .done_o(done), .err_o(err), .bus_req_o(req), .bus_we_o(we),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_ack_i(ack)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [31:0] mem [256];
  int   lat = 0, drop_addr = -1, cnt = 0;
  logic [8:0] last_key = '1;
  int   nlog = 0;
  logic       log_we   [32];
  logic [7:0] log_addr [32];
  logic [31:0] log_dat [32];

  function automatic int pd_bit(int c); return (c == 0) ? 12 : 25 + c; endfunction
  function automatic int pd_adr(int c); return (c == 0) ? PA : PB; endfunction
  function automatic logic [4:0] scr_of(logic [4:0] t);
    logic [4:0] s = t ^ 5'd1;
    return (s == 0) ? 5'd2 : s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // register model with divider quirk: pd rising resets field to 1
  always @(negedge clk) begin
    if (!rst_n) begin
      ack = 1'b0; cnt = 0;
    end else begin
      if (ack) begin ack = 1'b0; cnt = 0; end
      if (req) begin
        if ({we, addr} != last_key) cnt = 0;
        last_key = {we, addr};
        if (int'(addr) != drop_addr && cnt == lat) begin
          ack = 1'b1;
          if (we) begin
            for (int c = 0; c < 6; c++)
              if (int'(addr) == pd_adr(c) && !mem[addr][pd_bit(c)] && wdata[pd_bit(c)])
                mem[DB + c][4:0] = 5'd1;
            mem[addr] = wdata;
            if (nlog < 32) begin log_we[nlog] = 1'b1; log_addr[nlog] = addr; log_dat[nlog] = wdata; end
          end else begin
            rdata = mem[addr];
            if (nlog < 32) begin log_we[nlog] = 1'b0; log_addr[nlog] = addr; log_dat[nlog] = rdata; end
          end
          nlog++;
        end else cnt++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic init_mem();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    mem[FA] = 32'h0000_F0A5; mem[IA] = 32'h0000_0F3E;
    mem[PA] = 32'h0000_0A05; mem[PB] = 32'h0000_0033;
    for (int c = 0; c < 6; c++) mem[DB + c] = 32'hABCD_EF00 | 32'(c + 3);
    nlog = 0;
  endtask

  task automatic kick(input int c, input logic [4:0] t);
    @(negedge clk); start = 1'b1; chan = 3'(c); tgt = t;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(output logic e);
    int k = 0;
    e = 1'b0;
    while (!done && k < 3000) begin @(negedge clk); k++; end
    chk("R7 done seen", 32'(done), 32'd1);
    e = err;
    @(negedge clk);
    chk("R7 done one cycle", 32'(done), 32'd0);
    chk("R7 idle after done", 32'(busy), 32'd0);
  endtask

  task automatic check_seq(input int c, input logic [4:0] t, input logic [31:0] f0, i0, p0, d0);
    logic [31:0] m = 32'd1 << c, pm = 32'd1 << pd_bit(c);
    logic [31:0] d1 = {d0[31:5], 5'd1};
    logic [7:0] ea [14];
    logic       ew [14];
    logic [31:0] ed [14];
    ea = '{8'(FA),8'(FA),8'(IA),8'(IA),8'(pd_adr(c)),8'(pd_adr(c)),8'(pd_adr(c)),
           8'(DB+c),8'(DB+c),8'(DB+c),8'(FA),8'(FA),8'(IA),8'(IA)};
    ew = '{0,1,0,1,0,1,1,0,1,1,0,1,0,1};
    ed = '{f0, f0 & ~m, i0, i0 & ~m, p0, p0 | pm, p0 & ~pm, d1,
           {d0[31:5], scr_of(t)}, {d0[31:5], t}, f0 & ~m, f0, i0 & ~m, i0};
    chk("R1 access count", 32'(nlog), 32'd14);
    for (int k = 0; k < 14 && k < nlog; k++) begin
      chk($sformatf("R1 addr step %0d", k), 32'(log_addr[k]), 32'(ea[k]));
      chk($sformatf("R1 dir step %0d", k), 32'(log_we[k]), 32'(ew[k]));
    end
    if (nlog >= 14) begin
      chk("R2 func gate", log_dat[1], ed[1]);
      chk("R2 iface gate", log_dat[3], ed[3]);
      chk("R3 pd set", log_dat[5], ed[5]);
      chk("R3 pd clear", log_dat[6], ed[6]);
      chk("R4 scratch", log_dat[8], ed[8]);
      chk("R4 scratch differs", 32'(log_dat[8][4:0] != t), 32'd1);
      chk("R5 target write", log_dat[9], ed[9]);
      chk("R6 func restore", log_dat[11], ed[11]);
      chk("R6 iface restore", log_dat[13], ed[13]);
    end
    chk("R5 final divide", mem[DB + c], {d0[31:5], t});
    chk("R6 func reg", mem[FA], f0);
    chk("R6 iface reg", mem[IA], i0);
    chk("R3 pd reg", mem[pd_adr(c)], p0);
  endtask

  task automatic t_reset();
    chk("R7 reset busy", 32'(busy), 0);
    chk("R7 reset done", 32'(done), 0);
    chk("R7 reset err", 32'(err), 0);
    chk("R7 reset req", 32'(req), 0);
  endtask

  task automatic t_basic(input int c, input logic [4:0] t);
    logic e;
    logic [31:0] f0, i0, p0, d0;
    init_mem();
    f0 = mem[FA]; i0 = mem[IA]; p0 = mem[pd_adr(c)]; d0 = mem[DB + c];
    kick(c, t);
    chk("R7 busy after start", 32'(busy), 1);
    wait_done(e);
    chk("R10 no error", 32'(e), 0);
    check_seq(c, t, f0, i0, p0, d0);
  endtask

  task automatic t_busy_ignore();
    logic e;
    logic [31:0] f0, i0, p0, d0;
    init_mem();
    f0 = mem[FA]; i0 = mem[IA]; p0 = mem[PB]; d0 = mem[DB + 2];
    kick(2, 5'd12);
    repeat (4) @(negedge clk);
    start = 1'b1; chan = 3'd4; tgt = 5'd3;
    @(negedge clk); start = 1'b0;
    wait_done(e);
    repeat (3) @(negedge clk);
    chk("R8 start while busy ignored", 32'(busy), 0);
    check_seq(2, 5'd12, f0, i0, p0, d0);
    chk("R8 other channel untouched", mem[DB + 4], 32'hABCD_EF07);
  endtask

  task automatic t_bad_chan();
    init_mem();
    kick(7, 5'd4);
    @(negedge clk);
    chk("R8 bad channel busy", 32'(busy), 0);
    chk("R8 bad channel req", 32'(req), 0);
    chk("R8 bad channel no access", 32'(nlog), 0);
  endtask

  task automatic t_ack_limit();
    logic e;
    logic [31:0] f0, i0, p0, d0;
    init_mem();
    lat = TO_CYC;
    f0 = mem[FA]; i0 = mem[IA]; p0 = mem[PB]; d0 = mem[DB + 5];
    kick(5, 5'd20);
    wait_done(e);
    chk("R9 ack at limit no error", 32'(e), 0);
    check_seq(5, 5'd20, f0, i0, p0, d0);
    lat = 0;
  endtask

  task automatic t_timeout();
    logic e;
    logic [31:0] f0, i0;
    init_mem();
    mem[FA] = 32'h0000_0008; mem[IA] = 32'h0000_00F0;
    f0 = mem[FA]; i0 = mem[IA];
    drop_addr = DB + 3;
    kick(3, 5'd9);
    wait_done(e);
    chk("R10 error with done", 32'(e), 1);
    chk("R10 access count", 32'(nlog), 32'd11);
    if (nlog >= 11) begin
      chk("R10 restore read addr", 32'(log_addr[7]), FA);
      chk("R10 restore func data", log_dat[8], f0);
      chk("R10 restore iface data", log_dat[10], i0);
    end
    chk("R10 func reg restored", mem[FA], f0);
    chk("R10 iface reg restored", mem[IA], i0);
    drop_addr = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic(1, 5'd6);
    t_basic(0, 5'd1);
    mem[FA] = 0;
    t_basic(4, 5'd0);
    t_busy_ignore();
    t_bad_chan();
    t_ack_limit();
    t_timeout();
    t_basic(5, 5'd31);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule